// File: doc/BRIEF.md
# Load-Linked Reservation Monitor

This block tracks the one reservation that backs an atomic read-modify-write sequence. The sequence is a linked load followed by a conditional store. The core reports four kinds of event to the block: a linked load with its address, a conditional store attempt with its address, an ordinary store with its address, and the execution of an exception return. The block answers each conditional store attempt in the same cycle, saying whether that store may complete.

A linked load arms the reservation and records the word that holds the loaded address. The reservation is then dropped by any of these events:
- the conditional store itself, whether it succeeds or fails;
- an ordinary store that writes the reserved word;
- an exception return.

When a linked load arrives in the same cycle as any dropping event, the linked load takes priority. Coherence snooping from other masters, the memory write, and the register write-back of the result all belong to logic outside this block.

Top module: `llmon_top`

## Requirements
- R1: A synchronous active-high reset clears the reservation flag (`resv_flag` reads 0 in the cycle after reset is sampled), including when a reservation is active.
- R2: A linked load sets `resv_flag` in the next cycle and records the word address, which is the address with its low two bits dropped. Those two bits play no part in any later comparison.
- R3: `sc_ok` is high in the same cycle as a conditional store attempt exactly when the flag is set and the store's word address equals the recorded word address. `sc_ok` is low in every cycle with no attempt.
- R4: A conditional store attempt clears the flag for the next cycle, whether it succeeds or fails.
- R5: An ordinary store whose word address equals the recorded word clears the flag.
- R6: An ordinary store to any other word leaves the flag and the recorded address unchanged.
- R7: An exception return clears the flag.
- R8: When a linked load coincides with a conditional store, a matching ordinary store, or an exception return, the flag is set after that cycle and the new address is recorded.
- R9: A conditional store that coincides with a linked load is judged against the reservation that was held before that cycle.
- R10: A new linked load replaces the recorded address, so a conditional store to the previously recorded word then fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ll_valid | input | 1 | Linked load executes this cycle |
| ll_addr | input | AW | Byte address of the linked load |
| sc_valid | input | 1 | Conditional store attempted this cycle |
| sc_addr | input | AW | Byte address of the conditional store |
| st_valid | input | 1 | Ordinary store executes this cycle |
| st_addr | input | AW | Byte address of the ordinary store |
| eret_valid | input | 1 | Exception return executes this cycle |
| sc_ok | output | 1 | Conditional store may succeed (same cycle) |
| resv_flag | output | 1 | Registered reservation flag |

## Verification
A stale or wrong recorded address does not show on any port on its own. It appears only at the next conditional store, when `sc_ok` gives the wrong answer in that same cycle. For that reason the bench follows every arming sequence with an attempt to a matching word or to a neighbouring word.

A wrong flag shows on `resv_flag` one cycle after the event that caused it. The bench therefore compares the flag after every step, covering stores that hit the reserved word, stores that miss it, exception returns, and events that coincide with a linked load.

// File: rtl/llmon_pkg.sv
package llmon_pkg;
  // Next action applied to the reservation register
  typedef enum logic [1:0] {
    RESV_HOLD = 2'd0,
    RESV_ARM  = 2'd1,
    RESV_DROP = 2'd2
  } resv_act_e;
endpackage

// File: rtl/llmon_wordsel.sv
module llmon_wordsel #(
  parameter int AW   = 32,
  parameter int OFFB = 2
) (
  input  logic [AW-1:0]      byte_addr,
  output logic [AW-OFFB-1:0] word_addr
);
  logic unused_off;
  assign unused_off = ^byte_addr[OFFB-1:0];
  assign word_addr  = byte_addr[AW-1:OFFB];
endmodule

// File: rtl/llmon_match.sv
module llmon_match #(
  parameter int WAW = 30
) (
  input  logic           en,
  input  logic [WAW-1:0] a,
  input  logic [WAW-1:0] b,
  output logic           hit
);
  assign hit = en && (a == b);
endmodule

// File: rtl/llmon_arbiter.sv
module llmon_arbiter
  import llmon_pkg::*;
(
  input  logic      ll_valid,
  input  logic      sc_valid,
  input  logic      st_hit,
  input  logic      eret_valid,
  output resv_act_e act
);
  always_comb begin
    if (ll_valid)                            act = RESV_ARM;
    else if (sc_valid || st_hit || eret_valid) act = RESV_DROP;
    else                                     act = RESV_HOLD;
  end
endmodule

// File: rtl/llmon_resv.sv
module llmon_resv
  import llmon_pkg::*;
#(
  parameter int WAW = 30
) (
  input  logic           clk,
  input  logic           rst,
  input  resv_act_e      act,
  input  logic [WAW-1:0] arm_word,
  output logic           flag,
  output logic [WAW-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      word <= '0;
    end else begin
      case (act)
        RESV_ARM: begin
          flag <= 1'b1;
          word <= arm_word;
        end
        RESV_DROP: flag <= 1'b0;
        default:   flag <= flag;
      endcase
    end
  end
endmodule

// File: rtl/llmon_top.sv
module llmon_top
  import llmon_pkg::*;
#(
  parameter int AW   = 32,
  parameter int OFFB = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ll_valid,
  input  logic [AW-1:0] ll_addr,
  input  logic          sc_valid,
  input  logic [AW-1:0] sc_addr,
  input  logic          st_valid,
  input  logic [AW-1:0] st_addr,
  input  logic          eret_valid,
  output logic          sc_ok,
  output logic          resv_flag
);
  localparam int WAW = AW - OFFB;

  logic [WAW-1:0] ll_word, sc_word, st_word, resv_word;
  logic           st_hit, sc_hit;
  resv_act_e      act;

  llmon_wordsel #(.AW(AW), .OFFB(OFFB)) u_ws_ll (.byte_addr(ll_addr), .word_addr(ll_word));
  llmon_wordsel #(.AW(AW), .OFFB(OFFB)) u_ws_sc (.byte_addr(sc_addr), .word_addr(sc_word));
  llmon_wordsel #(.AW(AW), .OFFB(OFFB)) u_ws_st (.byte_addr(st_addr), .word_addr(st_word));

  llmon_match #(.WAW(WAW)) u_st_cmp (
    .en(st_valid && resv_flag), .a(st_word), .b(resv_word), .hit(st_hit));
  llmon_match #(.WAW(WAW)) u_sc_cmp (
    .en(sc_valid && resv_flag), .a(sc_word), .b(resv_word), .hit(sc_hit));

  llmon_arbiter u_arb (
    .ll_valid(ll_valid), .sc_valid(sc_valid), .st_hit(st_hit),
    .eret_valid(eret_valid), .act(act));

  llmon_resv #(.WAW(WAW)) u_resv (
    .clk(clk), .rst(rst), .act(act), .arm_word(ll_word),
    .flag(resv_flag), .word(resv_word));

  assign sc_ok = sc_hit;
endmodule

// File: rtl/llmon_chk.sv
module llmon_chk #(
  parameter int AW   = 32,
  parameter int OFFB = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          ll_valid,
  input logic [AW-1:0] ll_addr,
  input logic          sc_valid,
  input logic [AW-1:0] sc_addr,
  input logic          st_valid,
  input logic [AW-1:0] st_addr,
  input logic          eret_valid,
  input logic          sc_ok,
  input logic          resv_flag
);
  // Independent record of the last armed word
  logic [AW-OFFB-1:0] shadow;
  always_ff @(posedge clk) begin
    if (rst) shadow <= '0;
    else if (ll_valid) shadow <= ll_addr[AW-1:OFFB];
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> !resv_flag);

  assert_ll_arms_R2_R8: assert property (@(posedge clk) disable iff (rst)
    ll_valid |=> resv_flag);

  assert_sc_answer_R3: assert property (@(posedge clk) disable iff (rst)
    sc_ok == (sc_valid && resv_flag && (sc_addr[AW-1:OFFB] == shadow)));

  assert_sc_drops_R4: assert property (@(posedge clk) disable iff (rst)
    (sc_valid && !ll_valid) |=> !resv_flag);

  assert_store_hit_drops_R5: assert property (@(posedge clk) disable iff (rst)
    (st_valid && !ll_valid && resv_flag && (st_addr[AW-1:OFFB] == shadow)) |=> !resv_flag);

  assert_store_miss_keeps_R6: assert property (@(posedge clk) disable iff (rst)
    (resv_flag && st_valid && !ll_valid && !sc_valid && !eret_valid &&
     (st_addr[AW-1:OFFB] != shadow)) |=> resv_flag);

  assert_eret_drops_R7: assert property (@(posedge clk) disable iff (rst)
    (eret_valid && !ll_valid) |=> !resv_flag);

  assert_rise_needs_ll_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(resv_flag) |-> $past(ll_valid));
endmodule

bind llmon_top llmon_chk #(.AW(AW), .OFFB(OFFB)) u_chk (
  .clk(clk), .rst(rst), .ll_valid(ll_valid), .ll_addr(ll_addr),
  .sc_valid(sc_valid), .sc_addr(sc_addr), .st_valid(st_valid),
  .st_addr(st_addr), .eret_valid(eret_valid), .sc_ok(sc_ok),
  .resv_flag(resv_flag));

// File: tb/sim_llmon_top.sv
`timescale 1ns/100ps
module sim_llmon_top;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ll_valid = 1'b0, sc_valid = 1'b0, st_valid = 1'b0, eret_valid = 1'b0;
  logic [AW-1:0] ll_addr = '0, sc_addr = '0, st_addr = '0;
  logic          sc_ok, resv_flag;

  int total = 0;
  int bad   = 0;

  typedef struct {
    logic  exp_ok;
    logic  exp_flag;
    string req;
  } item_t;
  item_t sbq[$];

  always #2.5 clk = ~clk;

  llmon_top #(.AW(AW), .OFFB(2)) u0 (
    .clk(clk), .rst(rst), .ll_valid(ll_valid), .ll_addr(ll_addr),
    .sc_valid(sc_valid), .sc_addr(sc_addr), .st_valid(st_valid),
    .st_addr(st_addr), .eret_valid(eret_valid), .sc_ok(sc_ok),
    .resv_flag(resv_flag));

  // Driver: one cycle of events, expected answers go to the scoreboard
  task automatic step(input logic r, input logic ll, input logic [AW-1:0] la,
                      input logic sc, input logic [AW-1:0] sa,
                      input logic st, input logic [AW-1:0] ta,
                      input logic er, input logic eok, input logic eflag,
                      input string req);
    item_t it;
    @(negedge clk);
    rst = r; ll_valid = ll; ll_addr = la; sc_valid = sc; sc_addr = sa;
    st_valid = st; st_addr = ta; eret_valid = er;
    it.exp_ok = eok; it.exp_flag = eflag; it.req = req;
    sbq.push_back(it);
  endtask

  // Monitor: sc_ok after inputs settle, flag just after the edge
  initial begin
    forever begin
      item_t it;
      @(negedge clk);
      #1;
      if (sbq.size() > 0) begin
        it = sbq.pop_front();
        total++;
        if (sc_ok !== it.exp_ok) begin
          bad++;
          $display("FAIL %s sc_ok actual=%b expected=%b", it.req, sc_ok, it.exp_ok);
        end
        @(posedge clk);
        #1;
        total++;
        if (resv_flag !== it.exp_flag) begin
          bad++;
          $display("FAIL %s resv_flag actual=%b expected=%b", it.req, resv_flag, it.exp_flag);
        end
      end
    end
  end

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    total++;
    if (resv_flag !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset flag actual=%b expected=0", resv_flag);
    end
    //   rst ll  la        sc  sa        st  ta        er  ok  flag
    step(0, 0, 0,        1, 32'h100, 0, 0,        0, 0, 0, "R3 no reservation");
    step(0, 1, 32'h103,  0, 0,       0, 0,        0, 0, 1, "R2 ll arms");
    step(0, 0, 0,        1, 32'h100, 0, 0,        0, 1, 0, "R3 R4 match low bits ignored");
    step(0, 0, 0,        1, 32'h100, 0, 0,        0, 0, 0, "R4 second sc fails");
    step(0, 1, 32'h200,  0, 0,       0, 0,        0, 0, 1, "R2 arm 200");
    step(0, 0, 0,        0, 0,       1, 32'h204,  0, 0, 1, "R6 store other word");
    step(0, 0, 0,        1, 32'h208, 0, 0,        0, 0, 0, "R3 R4 mismatch fails and clears");
    step(0, 1, 32'h200,  0, 0,       0, 0,        0, 0, 1, "R2 rearm 200");
    step(0, 0, 0,        0, 0,       1, 32'h202,  0, 0, 0, "R5 store same word");
    step(0, 0, 0,        1, 32'h200, 0, 0,        0, 0, 0, "R5 sc after store hit");
    step(0, 1, 32'h300,  0, 0,       0, 0,        0, 0, 1, "R2 arm 300");
    step(0, 0, 0,        0, 0,       0, 0,        1, 0, 0, "R7 eret clears");
    step(0, 1, 32'h400,  0, 0,       1, 32'h400,  1, 0, 1, "R8 ll beats store and eret");
    step(0, 0, 0,        1, 32'h401, 0, 0,        0, 1, 0, "R8 sc after priority");
    step(0, 1, 32'h500,  0, 0,       0, 0,        0, 0, 1, "R10 arm 500");
    step(0, 1, 32'h600,  0, 0,       0, 0,        0, 0, 1, "R10 arm 600");
    step(0, 0, 0,        1, 32'h500, 0, 0,        0, 0, 0, "R10 old word fails");
    step(0, 1, 32'h700,  0, 0,       0, 0,        0, 0, 1, "R2 arm 700");
    step(0, 1, 32'h800,  1, 32'h700, 0, 0,        0, 1, 1, "R9 R8 sc vs prior, ll wins");
    step(0, 0, 0,        1, 32'h800, 0, 0,        0, 1, 0, "R9 new word succeeds");
    step(0, 1, 32'h900,  0, 0,       0, 0,        0, 0, 1, "R2 arm 900");
    step(1, 0, 0,        0, 0,       0, 0,        0, 0, 0, "R1 reset mid-run");
    step(0, 0, 0,        1, 32'h900, 0, 0,        0, 0, 0, "R1 sc after reset");
    step(0, 0, 0,        0, 0,       0, 0,        0, 0, 0, "R3 idle");
    repeat (4) @(posedge clk);
    #1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule